// File: doc/BRIEF.md
# Two-Thread Buffer Allocator with Partition Limits

This block sits between a micro-op queue shared by two hardware threads and the out-of-order core's tracked buffers. Each cycle it looks at the head op of each thread. Every op needs one reorder-buffer slot. A load also needs a load-buffer slot, and a store also needs a store-buffer slot. The block picks at most one op per cycle to allocate. It keeps an occupancy count per thread for each of the three pools, and it decrements those counts on release pulses from retirement.

When both threads run (partitioned mode), each thread may hold at most half of each pool. A thread that cannot get every pool it needs sees its stall line raised, and the other thread keeps allocating. When only one thread runs (combined mode), the caps widen to the full pool, so a single thread gets the whole machine. When both threads are eligible, the choice alternates between them so that neither thread is starved.

`take_o` tells the queue which head op is consumed at the coming clock edge. It is a combinational function of the current inputs and the registered counters.

Top module: `dual_thread_alloc`

## Requirements
- R1: During reset and on the first cycle after it, all counts are zero, no op is taken, no stall is raised, and thread 0 holds the first preference.
- R2: An op is taken only when every pool it needs has room: the reorder buffer always, the load buffer when its load flag is 1, and the store buffer when its store flag is 1. An op that is not taken changes no count.
- R3: In partitioned mode (`shared_mode_i` = 0), a thread may hold at most 63 of 126 reorder slots, 24 of 48 load slots and 12 of 24 store slots.
- R4: In combined mode (`shared_mode_i` = 1), one thread may hold up to the full capacity of a pool. The sum over both threads never exceeds that capacity.
- R5: When both threads are eligible in the same cycle, the thread not served by the most recent grant is taken, so grants alternate.
- R6: When only one thread is eligible, because the other has no op or is stalled, that thread is taken in the same cycle.
- R7: `stall_o[t]` is 1 exactly when thread t presents an op and some pool that op needs lacks room for thread t. A stalled thread is never taken, and the other thread is unaffected.
- R8: A release pulse lowers that thread's count in that pool by one at the clock edge. Room is judged on the count before the edge, so a release frees space from the next cycle. A take and a release of the same pool in the same cycle cancel.
- R9: At most one bit of `take_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode_i | input | 1 | 0 = partitioned (half-pool caps), 1 = combined (full-pool caps) |
| op_valid_i | input | 2 | Bit t: thread t has a head op waiting |
| op_load_i | input | 2 | Bit t: head op of thread t needs a load-buffer slot |
| op_store_i | input | 2 | Bit t: head op of thread t needs a store-buffer slot |
| rel_rob_i | input | 2 | Bit t: free one reorder slot of thread t |
| rel_ld_i | input | 2 | Bit t: free one load slot of thread t |
| rel_st_i | input | 2 | Bit t: free one store slot of thread t |
| take_o | output | 2 | Bit t: head op of thread t is allocated at this edge |
| stall_o | output | 2 | Bit t: head op of thread t is blocked by a full pool |

## Verification
A count that drifts from the number of takes minus the number of releases does not show up as an error right away. It shows up as a stall that comes too early, or an allocation that goes past a cap, on the first op that reaches the boundary. The bench therefore drives each pool to its cap in both modes and compares `take_o` and `stall_o` every cycle against a reference count model. A wrong preference register shows in the very next cycle in which both threads are eligible. A partial allocation by a stalled op shows later, as one slot too few when that pool is filled to its cap.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam int NTH = 2;
  localparam int NPOOL = 3;

  typedef enum int {
    POOL_ROB = 0,
    POOL_LD  = 1,
    POOL_ST  = 2
  } pool_e;

  function automatic int pool_cap(input int idx, input int rob_n, input int ld_n, input int st_n);
    case (idx)
      POOL_ROB: return rob_n;
      POOL_LD:  return ld_n;
      default:  return st_n;
    endcase
  endfunction
endpackage

// File: rtl/dta_pool.sv
module dta_pool #(
  parameter int CAP = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       comb_i,
  input  logic [1:0] alloc_i,
  input  logic [1:0] rel_i,
  output logic [1:0] room_o
);
  localparam int W    = $clog2(CAP + 1);
  localparam int HALF = CAP / 2;

  logic [W-1:0] cnt [2];
  logic [W:0]   total;
  logic [W-1:0] lim;

  assign total = {1'b0, cnt[0]} + {1'b0, cnt[1]};
  assign lim   = comb_i ? W'(CAP) : W'(HALF);

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign room_o[t] = (cnt[t] < lim) && (total < (W+1)'(CAP));

    always_ff @(posedge clk) begin
      if (rst) cnt[t] <= '0;
      else     cnt[t] <= cnt[t] + W'(alloc_i[t]) - W'(rel_i[t]);
    end

    assert_alloc_has_room_R2: assert property (@(posedge clk) disable iff (rst)
      alloc_i[t] |-> room_o[t]);
    assert_partition_cap_R3: assert property (@(posedge clk) disable iff (rst)
      (alloc_i[t] && !comb_i) |=> (cnt[t] <= W'(HALF)));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
      (rel_i[t] && !alloc_i[t]) |-> (cnt[t] != '0));
  end

  assert_total_bound_R4: assert property (@(posedge clk) disable iff (rst)
    total <= (W+1)'(CAP));
endmodule

// File: rtl/dta_pick.sv
module dta_pick (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] elig_i,
  output logic [1:0] take_o
);
  logic turn;

  always_comb begin
    take_o = 2'b00;
    if (!rst) begin
      if (elig_i == 2'b11) take_o[turn] = 1'b1;
      else                 take_o = elig_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            turn <= 1'b0;
    else if (take_o[0]) turn <= 1'b1;
    else if (take_o[1]) turn <= 1'b0;
  end

  assert_one_take_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_o));
  assert_alt_after0_R5: assert property (@(posedge clk) disable iff (rst)
    (take_o == 2'b01) |=> ((elig_i == 2'b11) -> (take_o == 2'b10)));
  assert_alt_after1_R5: assert property (@(posedge clk) disable iff (rst)
    (take_o == 2'b10) |=> ((elig_i == 2'b11) -> (take_o == 2'b01)));
  assert_lone_served_R6: assert property (@(posedge clk) disable iff (rst)
    ((elig_i == 2'b01) |-> (take_o == 2'b01)) and ((elig_i == 2'b10) |-> (take_o == 2'b10)));
endmodule

// File: rtl/dual_thread_alloc.sv
module dual_thread_alloc #(
  parameter int ROB_N = 126,
  parameter int LD_N  = 48,
  parameter int ST_N  = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shared_mode_i,
  input  logic [1:0] op_valid_i,
  input  logic [1:0] op_load_i,
  input  logic [1:0] op_store_i,
  input  logic [1:0] rel_rob_i,
  input  logic [1:0] rel_ld_i,
  input  logic [1:0] rel_st_i,
  output logic [1:0] take_o,
  output logic [1:0] stall_o
);
  import dta_pkg::*;

  logic [1:0] need [NPOOL];
  logic [1:0] rel  [NPOOL];
  logic [1:0] room [NPOOL];
  logic [1:0] fits;
  logic [1:0] elig;

  always_comb begin
    need[POOL_ROB] = 2'b11;
    need[POOL_LD]  = op_load_i;
    need[POOL_ST]  = op_store_i;
    rel[POOL_ROB]  = rel_rob_i;
    rel[POOL_LD]   = rel_ld_i;
    rel[POOL_ST]   = rel_st_i;
    fits = 2'b11;
    for (int p = 0; p < NPOOL; p++) fits = fits & (room[p] | ~need[p]);
  end

  assign elig    = op_valid_i & fits;
  assign stall_o = op_valid_i & ~fits;

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    localparam int CAP = pool_cap(p, ROB_N, LD_N, ST_N);
    dta_pool #(.CAP(CAP)) u_pool (
      .clk    (clk),
      .rst    (rst),
      .comb_i (shared_mode_i),
      .alloc_i(take_o & need[p]),
      .rel_i  (rel[p]),
      .room_o (room[p])
    );
  end

  dta_pick u_pick (
    .clk   (clk),
    .rst   (rst),
    .elig_i(elig),
    .take_o(take_o)
  );

  assert_stall_excl_R7: assert property (@(posedge clk) disable iff (rst)
    (stall_o & take_o) == 2'b00);
endmodule

// File: tb/dual_thread_alloc_tb.sv
module dual_thread_alloc_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shared_mode_i = 1'b0;
  logic [1:0] op_valid_i = '0, op_load_i = '0, op_store_i = '0;
  logic [1:0] rel_rob_i = '0, rel_ld_i = '0, rel_st_i = '0;
  logic [1:0] take_o, stall_o;

  always #(CLK_P/2) clk = ~clk;

  dual_thread_alloc u_dut (
    .clk(clk), .rst(rst), .shared_mode_i(shared_mode_i),
    .op_valid_i(op_valid_i), .op_load_i(op_load_i), .op_store_i(op_store_i),
    .rel_rob_i(rel_rob_i), .rel_ld_i(rel_ld_i), .rel_st_i(rel_st_i),
    .take_o(take_o), .stall_o(stall_o)
  );

  typedef struct {
    logic [1:0] take;
    logic [1:0] stall;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int cap [3] = '{126, 48, 24};
  int m_cnt [3][2];
  bit m_turn = 0;
  bit mode = 0;

  task automatic step(input logic [1:0] v, input logic [1:0] ld, input logic [1:0] st,
                      input logic [1:0] rr, input logic [1:0] rl, input logic [1:0] rs,
                      input string tag);
    logic [1:0] nd [3];
    logic [1:0] rl_ok [3];
    logic [1:0] ok, el, tk, sl;
    exp_t e;
    @(negedge clk);
    nd[0] = 2'b11; nd[1] = ld; nd[2] = st;
    rl_ok[0] = rr; rl_ok[1] = rl; rl_ok[2] = rs;
    for (int p = 0; p < 3; p++)
      for (int t = 0; t < 2; t++)
        if (m_cnt[p][t] == 0) rl_ok[p][t] = 1'b0;
    shared_mode_i = mode;
    op_valid_i = v; op_load_i = ld; op_store_i = st;
    rel_rob_i = rl_ok[0]; rel_ld_i = rl_ok[1]; rel_st_i = rl_ok[2];
    ok = 2'b11;
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 3; p++) begin
        int lim;
        lim = mode ? cap[p] : cap[p] / 2;
        if (nd[p][t] && !(m_cnt[p][t] < lim && (m_cnt[p][0] + m_cnt[p][1]) < cap[p]))
          ok[t] = 1'b0;
      end
    el = v & ok;
    sl = v & ~ok;
    if (el == 2'b11) tk = m_turn ? 2'b10 : 2'b01;
    else             tk = el;
    if (tk[0]) m_turn = 1;
    else if (tk[1]) m_turn = 0;
    for (int p = 0; p < 3; p++)
      for (int t = 0; t < 2; t++)
        m_cnt[p][t] = m_cnt[p][t] + int'(tk[t] & nd[p][t]) - int'(rl_ok[p][t]);
    e.take = tk; e.stall = sl; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (take_o !== e.take || stall_o !== e.stall) begin
        fails++;
        $display("FAIL %s take=%b stall=%b expected take=%b stall=%b at %0t",
                 e.tag, take_o, stall_o, e.take, e.stall, $time);
      end
    end
  end

  task automatic drain_all();
    for (int i = 0; i < 130; i++) step(2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * WDOG);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      m_cnt[p][0] = 0;
      m_cnt[p][1] = 0;
    end
    op_valid_i = 2'b11;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    checks++;
    if (take_o !== 2'b00) begin
      fails++;
      $display("FAIL R1 take during reset=%b expected 00", take_o);
    end
    @(negedge clk);
    op_valid_i = 2'b00;
    rst = 1'b0;
    #(CLK_P/4);
    checks++;
    if (take_o !== 2'b00 || stall_o !== 2'b00) begin
      fails++;
      $display("FAIL R1 take=%b stall=%b expected 00 00", take_o, stall_o);
    end
    step(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, "R1");
    for (int i = 0; i < 5; i++) step(2'b01, 2'b00, 2'b00, 0, 0, 0, "R6");
    for (int i = 0; i < 8; i++) step(2'b11, 2'b00, 2'b00, 0, 0, 0, "R5");
    for (int i = 0; i < 70; i++) step(2'b01, 2'b00, 2'b00, 0, 0, 0, "R3");
    for (int i = 0; i < 6; i++) step(2'b11, 2'b00, 2'b00, 0, 0, 0, "R7");
    drain_all();
    for (int i = 0; i < 30; i++) step(2'b11, 2'b01, 2'b10, 0, 0, 0, "R3");
    step(2'b10, 2'b00, 2'b10, 0, 0, 2'b10, "R8");
    step(2'b10, 2'b00, 2'b10, 0, 0, 0, "R8");
    step(2'b10, 2'b10, 2'b10, 0, 0, 0, "R2");
    for (int i = 0; i < 30; i++) step(2'b10, 2'b10, 2'b00, 0, 0, 0, "R2");
    drain_all();
    mode = 1;
    for (int i = 0; i < 30; i++) step(2'b01, 2'b00, 2'b01, 0, 0, 0, "R4");
    step(2'b11, 2'b00, 2'b11, 0, 0, 0, "R4");
    step(2'b10, 2'b00, 2'b10, 0, 0, 2'b01, "R4");
    step(2'b10, 2'b00, 2'b10, 0, 0, 0, "R4");
    for (int i = 0; i < 140; i++) step(2'b01, 2'b00, 2'b00, 0, 0, 0, "R4");
    drain_all();
    for (int i = 0; i < 500; i++) begin
      if (i % 100 == 0) mode = $urandom_range(0, 1) == 1;
      step(2'($urandom), 2'($urandom), 2'($urandom),
           2'($urandom) & 2'($urandom), 2'($urandom) & 2'($urandom),
           2'($urandom) & 2'($urandom), "R9");
    end
    @(negedge clk);
    op_valid_i = 2'b00;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule